// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a windowed register file for a processor that keeps procedure state in registers instead of memory. The windowed storage is a ring of eight windows. Each procedure level sees 32 logical registers. Numbers 0 to 7 reach a shared global bank that never moves. Numbers 8 to 15 are the incoming arguments, 16 to 23 are private locals, and 24 to 31 are outgoing values. The outgoing group of one level is the same physical storage as the incoming group of the next level. A value that a caller places there is therefore seen by the callee as an argument, and no copy is made.

A current-window pointer selects the active window. A call moves the pointer forward by one and a return moves it back by one, with wrap-around at the end of the ring. The block counts how many windows are resident. A call that would overwrite a window still in use raises an overflow trap. A return that would need a caller window that is no longer resident raises an underflow trap. In both cases the pointer does not move. An external save/restore engine, which is not part of this block, handles the trap. It reports each window it has spilled to memory or filled back from memory through two acknowledge inputs, and these adjust the resident count.

The block has two combinational read ports and one synchronous write port. A read of the register being written in the same cycle returns the new data.

Top module: `regwin_file`

## Requirements
- R1: After reset, the window pointer `cwp_o` is 0, exactly one window is resident, and `ovf_o` and `unf_o` are low while no call or return is requested.
- R2: Logical numbers 0-7 (bits [4:3] = 00) select the global bank. A global written in one window reads back the same in every other window.
- R3: Logical numbers 16-23 (bits [4:3] = 10) are locals private to each window. A write to a local in one window does not change the same local number in the next window.
- R4: Logical numbers 24-31 (bits [4:3] = 11) of window w are the same storage as logical numbers 8-15 (bits [4:3] = 01) of window (w+1) mod 8, with the same low three bits. This includes window 7 aliasing window 0.
- R5: A call with fewer than 7 windows resident sets `cwp_o` to (cwp+1) mod 8 at the next edge. A return with more than 1 window resident sets `cwp_o` to (cwp-1) mod 8. With neither request, `cwp_o` holds.
- R6: A call while 7 windows are resident drives `ovf_o` high in that same cycle. The pointer and the resident count are left unchanged.
- R7: A return while only 1 window is resident drives `unf_o` high in that same cycle. The pointer and the resident count are left unchanged.
- R8: `spill_ack_i` lowers the resident count by one and is ignored when the count is 1. `fill_ack_i` raises the count by one and is ignored when the count is 7.
- R9: Only one control request acts per cycle, in the priority order call, return, spill acknowledge, fill acknowledge. Lower requests in the same cycle are ignored, even when the request that wins has no effect.
- R10: A read whose address equals the write address in the same cycle returns the write data on that port. A write that happens in the same cycle as a call goes to the window that was current before the call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Procedure call request |
| ret_i | input | 1 | Procedure return request |
| spill_ack_i | input | 1 | Oldest resident window has been saved to memory |
| fill_ack_i | input | 1 | A caller window has been restored from memory |
| ra_a | input | 5 | Logical read address, port A |
| ra_b | input | 5 | Logical read address, port B |
| rd_a | output | 32 | Read data, port A |
| rd_b | output | 32 | Read data, port B |
| we_i | input | 1 | Write enable |
| wa | input | 5 | Logical write address |
| wd | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Window overflow trap (call refused) |
| unf_o | output | 1 | Window underflow trap (return refused) |

## Verification
The bench covers two pairs of actions that can land in the same cycle.

The first pair is a register write and a read of that same register. The bench drives the write and points both read ports at the written address in one cycle. It compares the combinational outputs with the new data before the clock edge.

The second pair is a write and a call. The bench writes a local in the same cycle as a call, then returns. Reading the old data back from the caller's window shows that the write used the pointer value from before the call. Simultaneous control requests are also provoked, and they are judged through the trap outputs and the pointer movement that follow.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   // Region selected by the two top bits of a logical register number.
   typedef enum logic [1:0] {
      RG_GLOBAL = 2'b00,
      RG_ARGIN  = 2'b01,
      RG_LOCAL  = 2'b10,
      RG_ARGOUT = 2'b11
   } region_e;

   // Control action chosen in a cycle, highest priority first.
   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_CALL,
      ACT_RET,
      ACT_SPILL,
      ACT_FILL
   } act_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
   parameter int NWIN = 8,
   parameter int NREG = 8,
   localparam int CW = $clog2(NWIN),
   localparam int RW = $clog2(NREG),
   localparam int LW = RW + 2,
   localparam int PW = CW + 1 + RW
) (
   input  logic [CW-1:0] cwp,
   input  logic [LW-1:0] lreg,
   output logic          is_glob,
   output logic [PW-1:0] paddr
);
   import regwin_pkg::*;

   region_e       region;
   logic [RW-1:0] idx;
   logic [CW-1:0] next_win;

   assign region   = region_e'(lreg[LW-1:LW-2]);
   assign idx      = lreg[RW-1:0];
   assign next_win = cwp + CW'(1);

   // Each window owns 2*NREG unique entries: incoming half, then local half.
   // Outgoing registers land in the incoming half of the following window.
   always_comb begin
      is_glob = 1'b0;
      paddr   = '0;
      unique case (region)
         RG_GLOBAL: begin
            is_glob = 1'b1;
            paddr   = {{(CW+1){1'b0}}, idx};
         end
         RG_ARGIN:  paddr = {cwp, 1'b0, idx};
         RG_LOCAL:  paddr = {cwp, 1'b1, idx};
         RG_ARGOUT: paddr = {next_win, 1'b0, idx};
         default:   paddr = '0;
      endcase
   end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl #(
   parameter int NWIN = 8,
   localparam int CW = $clog2(NWIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call_i,
   input  logic          ret_i,
   input  logic          spill_ack_i,
   input  logic          fill_ack_i,
   output logic [CW-1:0] cwp,
   output logic          ovf,
   output logic          unf
);
   import regwin_pkg::*;

   localparam logic [CW-1:0] MAX_RES = CW'(NWIN - 1);
   localparam logic [CW-1:0] MIN_RES = CW'(1);

   logic [CW-1:0] resident;
   act_e          act;
   logic          full, lone;

   assign full = (resident == MAX_RES);
   assign lone = (resident == MIN_RES);

   always_comb begin
      if (call_i)           act = ACT_CALL;
      else if (ret_i)       act = ACT_RET;
      else if (spill_ack_i) act = ACT_SPILL;
      else if (fill_ack_i)  act = ACT_FILL;
      else                  act = ACT_NONE;
   end

   assign ovf = (act == ACT_CALL) && full;
   assign unf = (act == ACT_RET) && lone;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp      <= '0;
         resident <= MIN_RES;
      end else begin
         unique case (act)
            ACT_CALL: if (!full) begin
               cwp      <= cwp + CW'(1);
               resident <= resident + CW'(1);
            end
            ACT_RET: if (!lone) begin
               cwp      <= cwp - CW'(1);
               resident <= resident - CW'(1);
            end
            ACT_SPILL: if (!lone) resident <= resident - CW'(1);
            ACT_FILL:  if (!full) resident <= resident + CW'(1);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
   parameter int NWIN = 8,
   parameter int NREG = 8,
   parameter int DW   = 32,
   parameter int NRD  = 2,
   localparam int CW    = $clog2(NWIN),
   localparam int RW    = $clog2(NREG),
   localparam int PW    = CW + 1 + RW,
   localparam int NPHYS = NWIN * 2 * NREG
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic                     w_glob,
   input  logic [PW-1:0]            w_addr,
   input  logic [DW-1:0]            w_data,
   input  logic [NRD-1:0]           r_glob,
   input  logic [NRD-1:0][PW-1:0]   r_addr,
   output logic [NRD-1:0][DW-1:0]   r_data
);
   logic [DW-1:0] ring [NPHYS];
   logic [DW-1:0] gbank [NREG];

   always_ff @(posedge clk) begin
      if (we) begin
         if (w_glob) gbank[w_addr[RW-1:0]] <= w_data;
         else        ring[w_addr]          <= w_data;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic          hit;
      logic [DW-1:0] raw;
      assign hit = we && (r_glob[p] == w_glob) && (r_addr[p] == w_addr);
      assign raw = r_glob[p] ? gbank[r_addr[p][RW-1:0]] : ring[r_addr[p]];
      assign r_data[p] = hit ? w_data : raw;
   end
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
   parameter int NWIN = 8,
   parameter int NREG = 8,
   parameter int DW   = 32,
   localparam int CW = $clog2(NWIN),
   localparam int LW = $clog2(NREG) + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call_i,
   input  logic          ret_i,
   input  logic          spill_ack_i,
   input  logic          fill_ack_i,
   input  logic [LW-1:0] ra_a,
   input  logic [LW-1:0] ra_b,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b,
   input  logic          we_i,
   input  logic [LW-1:0] wa,
   input  logic [DW-1:0] wd,
   output logic [CW-1:0] cwp_o,
   output logic          ovf_o,
   output logic          unf_o
);
   localparam int RW   = $clog2(NREG);
   localparam int PW   = CW + 1 + RW;
   localparam int NRD  = 2;
   localparam int NMAP = NRD + 1;

   if (NWIN < 4 || (NWIN & (NWIN - 1)) != 0) begin : g_bad_nwin
      $error("regwin_file: NWIN must be a power of two, at least 4");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("regwin_file: NREG must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("regwin_file: DW must be positive");
   end

   logic [CW-1:0]                cwp;
   logic [NMAP-1:0][LW-1:0]      lsel;
   logic [NMAP-1:0]              pglob;
   logic [NMAP-1:0][PW-1:0]      paddr;
   logic [NRD-1:0][DW-1:0]       rdata;

   // Index NRD is the write port; lower indices are read ports.
   assign lsel[0]   = ra_a;
   assign lsel[1]   = ra_b;
   assign lsel[NRD] = wa;

   regwin_ctl #(.NWIN(NWIN)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .call_i      (call_i),
      .ret_i       (ret_i),
      .spill_ack_i (spill_ack_i),
      .fill_ack_i  (fill_ack_i),
      .cwp         (cwp),
      .ovf         (ovf_o),
      .unf         (unf_o)
   );

   for (genvar m = 0; m < NMAP; m++) begin : g_map
      regwin_map #(.NWIN(NWIN), .NREG(NREG)) u_map (
         .cwp     (cwp),
         .lreg    (lsel[m]),
         .is_glob (pglob[m]),
         .paddr   (paddr[m])
      );
   end

   regwin_store #(.NWIN(NWIN), .NREG(NREG), .DW(DW), .NRD(NRD)) u_store (
      .clk    (clk),
      .we     (we_i),
      .w_glob (pglob[NRD]),
      .w_addr (paddr[NRD]),
      .w_data (wd),
      .r_glob (pglob[NRD-1:0]),
      .r_addr (paddr[NRD-1:0]),
      .r_data (rdata)
   );

   assign rd_a  = rdata[0];
   assign rd_b  = rdata[1];
   assign cwp_o = cwp;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int NWIN = 8,
   parameter int NREG = 8,
   parameter int DW   = 32,
   localparam int CW = $clog2(NWIN),
   localparam int LW = $clog2(NREG) + 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          call_i,
   input logic          ret_i,
   input logic          we_i,
   input logic [LW-1:0] ra_a,
   input logic [LW-1:0] ra_b,
   input logic [LW-1:0] wa,
   input logic [DW-1:0] wd,
   input logic [DW-1:0] rd_a,
   input logic [DW-1:0] rd_b,
   input logic [CW-1:0] cwp_o,
   input logic          ovf_o,
   input logic          unf_o
);
   p_reset_r1: assert property (@(posedge clk) !rst_n |=> (cwp_o == '0));

   p_call_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ovf_o) |=> (cwp_o == CW'($past(cwp_o) + CW'(1))));

   p_ret_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && !unf_o) |=> (cwp_o == CW'($past(cwp_o) - CW'(1))));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_i && !ret_i) |=> $stable(cwp_o));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> $stable(cwp_o));

   p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> call_i);

   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> $stable(cwp_o));

   p_unf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |-> (ret_i && !call_i));

   p_bypass_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && ra_a == wa) |-> (rd_a == wd));

   p_bypass_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && ra_b == wa) |-> (rd_b == wd));
endmodule

bind regwin_file regwin_chk #(.NWIN(NWIN), .NREG(NREG), .DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .call_i (call_i),
   .ret_i  (ret_i),
   .we_i   (we_i),
   .ra_a   (ra_a),
   .ra_b   (ra_b),
   .wa     (wa),
   .wd     (wd),
   .rd_a   (rd_a),
   .rd_b   (rd_b),
   .cwp_o  (cwp_o),
   .ovf_o  (ovf_o),
   .unf_o  (unf_o)
);

// File: tb/sim_regwin_file.sv
`timescale 1ns/1ps
module sim_regwin_file;
   localparam int NWIN = 8;
   localparam int MAXR = NWIN - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0, ret_i = 1'b0, spill_ack_i = 1'b0, fill_ack_i = 1'b0;
   logic [4:0]  ra_a = '0, ra_b = '0, wa = '0;
   logic [31:0] rd_a, rd_b, wd = '0;
   logic        we_i = 1'b0;
   logic [2:0]  cwp_o;
   logic        ovf_o, unf_o;

   int n_chk = 0;
   int n_bad = 0;
   int mcwp = 0;
   int mcnt = 1;

   always #4 clk = ~clk;

   regwin_file u0 (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .spill_ack_i(spill_ack_i), .fill_ack_i(fill_ack_i),
      .ra_a(ra_a), .ra_b(ra_b), .rd_a(rd_a), .rd_b(rd_b),
      .we_i(we_i), .wa(wa), .wd(wd),
      .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mcwp = 0;
      mcnt = 1;
   endtask

   // One control cycle; the expected result is computed from R5-R9.
   task automatic step(input logic c, input logic r, input logic s, input logic f,
                       input string tag);
      logic eo, eu;
      @(negedge clk);
      call_i = c; ret_i = r; spill_ack_i = s; fill_ack_i = f;
      eo = c && (mcnt == MAXR);
      eu = !c && r && (mcnt == 1);
      #1;
      chk({tag, " ovf"}, 32'(ovf_o), 32'(eo));
      chk({tag, " unf"}, 32'(unf_o), 32'(eu));
      @(posedge clk);
      if (c) begin
         if (mcnt < MAXR) begin mcwp = (mcwp + 1) % NWIN; mcnt++; end
      end else if (r) begin
         if (mcnt > 1) begin mcwp = (mcwp + NWIN - 1) % NWIN; mcnt--; end
      end else if (s) begin
         if (mcnt > 1) mcnt--;
      end else if (f) begin
         if (mcnt < MAXR) mcnt++;
      end
      #1;
      call_i = 1'b0; ret_i = 1'b0; spill_ack_i = 1'b0; fill_ack_i = 1'b0;
      chk({tag, " cwp"}, 32'(cwp_o), 32'(mcwp));
   endtask

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      we_i = 1'b1; wa = a; wd = d;
      @(posedge clk);
      #1 we_i = 1'b0;
   endtask

   task automatic rreg(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      ra_a = a;
      #1 d = rd_a;
   endtask

   task automatic t_reset_r1();
      do_reset();
      #1;
      chk("R1 cwp after reset", 32'(cwp_o), 32'd0);
      chk("R1 ovf idle", 32'(ovf_o), 32'd0);
      chk("R1 unf idle", 32'(unf_o), 32'd0);
      step(1'b0, 1'b1, 1'b0, 1'b0, "R1 one resident window, R7 return");
   endtask

   task automatic t_global_r2();
      logic [31:0] d;
      wreg(5'd3, 32'hC0DE_0003);
      step(1'b1, 1'b0, 1'b0, 1'b0, "R2 call");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R2 call");
      rreg(5'd3, d);
      chk("R2 global seen two windows deeper", d, 32'hC0DE_0003);
      step(1'b0, 1'b1, 1'b0, 1'b0, "R2 ret");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R2 ret");
   endtask

   task automatic t_local_r3();
      logic [31:0] d;
      wreg(5'd18, 32'h1111_0018);
      step(1'b1, 1'b0, 1'b0, 1'b0, "R3 call");
      wreg(5'd18, 32'h2222_0018);
      rreg(5'd18, d);
      chk("R3 callee local", d, 32'h2222_0018);
      step(1'b0, 1'b1, 1'b0, 1'b0, "R3 ret");
      rreg(5'd18, d);
      chk("R3 caller local untouched", d, 32'h1111_0018);
   endtask

   task automatic t_alias_r4();
      logic [31:0] d;
      wreg(5'd29, 32'hA5A5_001D);
      step(1'b1, 1'b0, 1'b0, 1'b0, "R4 call");
      rreg(5'd13, d);
      chk("R4 caller out 29 is callee in 13", d, 32'hA5A5_001D);
      wreg(5'd9, 32'h5A5A_0009);
      step(1'b0, 1'b1, 1'b0, 1'b0, "R4 ret");
      rreg(5'd25, d);
      chk("R4 callee in 9 is caller out 25", d, 32'h5A5A_0009);
   endtask

   task automatic t_overflow_r6();
      logic [31:0] d;
      do_reset();
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R5 call chain");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R6 call with seven resident");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8 spill ack");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R8 call after spill");
      wreg(5'd24, 32'hBEEF_7018);
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8 spill ack");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R5 call wraps to window 0");
      rreg(5'd8, d);
      chk("R4 window 7 out aliases window 0 in", d, 32'hBEEF_7018);
   endtask

   task automatic t_underflow_r7();
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R5 return chain");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R7 return with one resident");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R8 fill ack");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R8 return after fill");
      for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R8 fill to limit");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R8 extra fill ignored, call overflows");
      do_reset();
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8 spill at one resident");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R8 spill ignored, return underflows");
   endtask

   task automatic t_priority_r9();
      do_reset();
      step(1'b1, 1'b1, 1'b0, 1'b0, "R9 call beats return");
      step(1'b0, 1'b1, 1'b1, 1'b0, "R9 return beats spill");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R9 ignored spill still masks fill");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R9 count stayed at one");
   endtask

   task automatic t_bypass_r10();
      logic [31:0] d;
      wreg(5'd20, 32'h0000_0001);
      @(negedge clk);
      we_i = 1'b1; wa = 5'd20; wd = 32'h7777_0014; ra_a = 5'd20; ra_b = 5'd20;
      #1;
      chk("R10 port A write-through", rd_a, 32'h7777_0014);
      chk("R10 port B write-through", rd_b, 32'h7777_0014);
      @(posedge clk);
      #1 we_i = 1'b0;
      @(negedge clk);
      ra_b = 5'd20;
      #1 chk("R10 port B stored value", rd_b, 32'h7777_0014);
      // write in the same cycle as a call lands in the old window
      @(negedge clk);
      we_i = 1'b1; wa = 5'd17; wd = 32'h9999_0011; call_i = 1'b1;
      @(posedge clk);
      mcwp = (mcwp + 1) % NWIN; mcnt++;
      #1 we_i = 1'b0; call_i = 1'b0;
      chk("R10 cwp after call with write", 32'(cwp_o), 32'(mcwp));
      step(1'b0, 1'b1, 1'b0, 1'b0, "R10 ret");
      rreg(5'd17, d);
      chk("R10 write used pre-call window", d, 32'h9999_0011);
   endtask

   initial begin
      t_reset_r1();
      t_global_r2();
      t_local_r3();
      t_alias_r4();
      t_overflow_r6();
      t_underflow_r7();
      t_priority_r9();
      t_bypass_r10();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule